// File: doc/BRIEF.md
# Memory Region Zeroize Sequencer

This block clears on-chip SRAM after a software request. A control write carries a 4-bit mask in which each bit names one of four fixed SRAM regions of unequal size. The sequencer then walks every selected region and writes zero words over its whole address range, using a simple write port toward the memory: address, write enable, data and a ready handshake. Regions are cleared one after another, lowest-numbered first.

While it works, the block reports busy and exposes the mask of regions that still wait to be cleared. Each mask bit drops when its region is finished. When the last region completes, busy falls and a one-cycle done pulse is raised. A trigger that arrives while the block is busy is dropped. A synchronous reset abandons any clearing in progress.

Top module: `mem_zeroize_seq`

## Requirements
- R1: After synchronous reset (rst high at a rising edge), pend_mask is 0, busy is 0, done is 0 and mem_we is 0.
- R2: When idle, a cycle with trig_we high and a nonzero trig_mask sets pend_mask to trig_mask and busy to 1 at that edge; a trigger with trig_mask equal to 0 leaves the block idle.
- R3: Mask bit 0 selects bytes 0x20000000 to 0x20007FFF, bit 1 selects 0x20008000 to 0x2000FFFF, bit 2 selects 0x20010000 to 0x2001BFFF, bit 3 selects 0x2001C000 to 0x2001FFFF; every selected region is written in full, in any combination.
- R4: Selected regions are cleared in ascending bit order, each region written from its lowest address upward.
- R5: Each write is a 32-bit zero word (mem_wdata is 0); the byte address advances by 4 only at an edge where mem_we and mem_ready are both high, and address and write enable are held while mem_ready is low.
- R6: A region's pend_mask bit clears at the same edge that its last word is accepted; bits of regions not yet finished stay set.
- R7: At the edge that accepts the final word of the last pending region, busy falls and done rises for exactly one cycle; done is never high at any other time.
- R8: A trigger write while busy is ignored: pend_mask and the address sequence continue unchanged.
- R9: Asserting rst during a run returns the block to idle with pend_mask 0 and no done pulse; a later trigger starts again at the first word of the lowest selected region.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| trig_we | input | 1 | Control register write strobe |
| trig_mask | input | 4 | Region-select mask written with trig_we |
| pend_mask | output | 4 | Regions still waiting to be cleared |
| busy | output | 1 | High while clearing is in progress |
| done | output | 1 | One-cycle pulse when the whole mask is finished |
| mem_addr | output | 32 | Byte address of the current word write |
| mem_we | output | 1 | Word write request |
| mem_wdata | output | 32 | Write data, always zero |
| mem_ready | input | 1 | Memory accepts the current write |

## Verification
The bench targets the seams between regions: non-adjacent masks such as 0101 and 1010, where a design that picked the next region wrongly or failed to reload the base address would write outside the selected ranges or skip one. It stalls the ready input on a fixed pattern, which catches a walker that advances without acceptance and so leaves holes in memory. It pokes the control register in mid-run, which a design without the busy guard would use to restart or widen the job, and it resets mid-run to show that no stray done pulse or leftover pending bit survives. The done pulse is checked for width and timing against the final accepted word, where an off-by-one count would end a region one word short or long.

// File: rtl/zs_pkg.sv
package zs_pkg;
  typedef enum logic {
    ZS_IDLE = 1'b0,
    ZS_RUN  = 1'b1
  } zs_state_t;
endpackage

// File: rtl/zs_pick.sv
module zs_pick #(
  parameter int NREG  = 4,
  parameter int IDX_W = 2
) (
  input  logic [NREG-1:0]  mask,
  output logic [IDX_W-1:0] idx
);
  // Lowest set bit wins; scan from the top so the last hit is the lowest.
  always_comb begin
    idx = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/zs_region_rom.sv
module zs_region_rom #(
  parameter int NREG   = 4,
  parameter int IDX_W  = 2,
  parameter int ADDR_W = 32,
  parameter int BYTE_SH = 2,
  parameter logic [NREG*ADDR_W-1:0] REG_BASE  = '0,
  parameter logic [NREG*ADDR_W-1:0] REG_BYTES = '0
) (
  input  logic [IDX_W-1:0]  idx,
  output logic [ADDR_W-1:0] base,
  output logic [ADDR_W-1:0] words_m1
);
  logic [ADDR_W-1:0] base_tab [NREG];
  logic [ADDR_W-1:0] cnt_tab  [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_tab
    assign base_tab[g] = REG_BASE[g*ADDR_W +: ADDR_W];
    assign cnt_tab[g]  = (REG_BYTES[g*ADDR_W +: ADDR_W] >> BYTE_SH) - ADDR_W'(1);
  end

  assign base     = base_tab[idx];
  assign words_m1 = cnt_tab[idx];
endmodule

// File: rtl/zs_walker.sv
module zs_walker #(
  parameter int ADDR_W     = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_base,
  input  logic [ADDR_W-1:0] load_words_m1,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              last
);
  logic [ADDR_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr   <= '0;
      remain <= '0;
    end else if (load) begin
      addr   <= load_base;
      remain <= load_words_m1;
    end else if (step) begin
      addr   <= addr + ADDR_W'(WORD_BYTES);
      remain <= remain - ADDR_W'(1);
    end
  end

  assign last = (remain == '0);
endmodule

// File: rtl/mem_zeroize_seq.sv
module mem_zeroize_seq #(
  parameter int NREG   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter logic [NREG*ADDR_W-1:0] REG_BASE =
    {32'h2001_C000, 32'h2001_0000, 32'h2000_8000, 32'h2000_0000},
  parameter logic [NREG*ADDR_W-1:0] REG_BYTES =
    {32'h0000_4000, 32'h0000_C000, 32'h0000_8000, 32'h0000_8000}
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              trig_we,
  input  logic [NREG-1:0]   trig_mask,
  output logic [NREG-1:0]   pend_mask,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ready
);
  import zs_pkg::*;

  localparam int IDX_W      = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int WORD_BYTES = DATA_W / 8;
  localparam int BYTE_SH    = $clog2(WORD_BYTES);

  zs_state_t         state;
  logic [NREG-1:0]   pend;
  logic [IDX_W-1:0]  cur;
  logic [NREG-1:0]   pend_after;
  logic [IDX_W-1:0]  idx_trig, idx_rest, idx_next;
  logic [ADDR_W-1:0] nxt_base, nxt_words_m1;
  logic              last_word, accept, start, region_end, move_on, walk_load;

  assign accept     = (state == ZS_RUN) && mem_ready;
  assign start      = (state == ZS_IDLE) && trig_we && (trig_mask != '0);
  assign region_end = accept && last_word;
  assign pend_after = pend & ~(NREG'(1) << cur);
  assign move_on    = region_end && (pend_after != '0);
  assign walk_load  = start || move_on;
  assign idx_next   = (state == ZS_IDLE) ? idx_trig : idx_rest;

  zs_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick_trig (
    .mask (trig_mask),
    .idx  (idx_trig)
  );

  zs_pick #(.NREG(NREG), .IDX_W(IDX_W)) u_pick_rest (
    .mask (pend_after),
    .idx  (idx_rest)
  );

  zs_region_rom #(
    .NREG(NREG), .IDX_W(IDX_W), .ADDR_W(ADDR_W), .BYTE_SH(BYTE_SH),
    .REG_BASE(REG_BASE), .REG_BYTES(REG_BYTES)
  ) u_rom (
    .idx      (idx_next),
    .base     (nxt_base),
    .words_m1 (nxt_words_m1)
  );

  zs_walker #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES)) u_walk (
    .clk           (clk),
    .rst           (rst),
    .load          (walk_load),
    .load_base     (nxt_base),
    .load_words_m1 (nxt_words_m1),
    .step          (accept && !last_word),
    .addr          (mem_addr),
    .last          (last_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ZS_IDLE;
      pend  <= '0;
      cur   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ZS_IDLE: begin
          if (start) begin
            pend  <= trig_mask;
            cur   <= idx_trig;
            state <= ZS_RUN;
          end
        end
        ZS_RUN: begin
          if (region_end) begin
            pend <= pend_after;
            if (pend_after == '0) begin
              state <= ZS_IDLE;
              done  <= 1'b1;
            end else begin
              cur <= idx_rest;
            end
          end
        end
        default: state <= ZS_IDLE;
      endcase
    end
  end

  assign pend_mask = pend;
  assign busy      = (state == ZS_RUN);
  assign mem_we    = (state == ZS_RUN);
  assign mem_wdata = '0;
endmodule

// File: rtl/zs_checker.sv
module zs_checker #(
  parameter int NREG   = 4,
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              trig_we,
  input logic [NREG-1:0]   pend_mask,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ready
);
  // R5: zero data on every write
  p_zero_data_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_wdata == '0));

  // R5: word-aligned addresses
  p_aligned_r5: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[1:0] == 2'b00));

  // R5: a stalled write holds its address and request
  p_stall_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_we && !mem_ready) |=> (mem_we && $stable(mem_addr)));

  // R8: no pending bit is added while busy
  p_no_new_bits_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && trig_we) |=> ((pend_mask & ~$past(pend_mask)) == '0));

  // R7: done only with an empty mask and idle
  p_done_idle_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && (pend_mask == '0)));

  // R7: done lasts one cycle
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R6: busy means something is still pending
  p_busy_pending_r6: assert property (@(posedge clk) disable iff (rst)
    busy |-> (pend_mask != '0));

  // R7: a normal end of run raises done
  p_fall_done_r7: assert property (@(posedge clk) disable iff (rst)
    ($fell(busy) && !$past(rst)) |-> done);
endmodule

bind mem_zeroize_seq zs_checker #(.NREG(NREG), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_zs_chk (
  .clk       (clk),
  .rst       (rst),
  .trig_we   (trig_we),
  .pend_mask (pend_mask),
  .busy      (busy),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_we    (mem_we),
  .mem_wdata (mem_wdata),
  .mem_ready (mem_ready)
);

// File: tb/mem_zeroize_seq_bench.sv
module mem_zeroize_seq_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        trig_we = 1'b0;
  logic [3:0]  trig_mask = 4'h0;
  logic [3:0]  pend_mask;
  logic        busy, done, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ready = 1'b1;

  int checks = 0;
  int errors = 0;

  logic [31:0] base_tab [4];
  int          words_tab [4];

  always #5 clk = ~clk;

  mem_zeroize_seq u_mem_zeroize_seq (
    .clk(clk), .rst(rst), .trig_we(trig_we), .trig_mask(trig_mask),
    .pend_mask(pend_mask), .busy(busy), .done(done),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_ready(mem_ready)
  );

  task automatic check(input string req, input bit ok,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int lowest(input logic [3:0] m);
    for (int i = 3; i >= 0; i--) if (m[i]) lowest = i;
    if (m == 4'h0) lowest = 0;
  endfunction

  // Trigger a mask and follow the whole run word by word.
  task automatic run_mask(input logic [3:0] mask, input bit stall, input bit poke);
    logic [3:0]  exp_pend = mask;
    int          r = lowest(mask);
    int          w = 0;
    int          cyc = 0;
    bit          rdy;
    bit          addr_bad = 0, data_bad = 0, pend_bad = 0, done_bad = 0;
    logic [31:0] a_act = 0, a_exp = 0, p_act = 0, p_exp = 0;
    @(negedge clk);
    trig_we = 1'b1; trig_mask = mask;
    @(negedge clk);
    trig_we = 1'b0; trig_mask = 4'h0;
    // R2: busy and pending mask loaded at the trigger edge
    check("R2 busy after trigger", busy === 1'b1, {31'd0, busy}, 32'd1);
    check("R2 pend after trigger", pend_mask === mask, {28'd0, pend_mask}, {28'd0, mask});
    forever begin
      if (pend_mask !== exp_pend && !pend_bad) begin
        pend_bad = 1; p_act = {28'd0, pend_mask}; p_exp = {28'd0, exp_pend};
      end
      if (exp_pend == 4'h0) break;
      if (done !== 1'b0) done_bad = 1;
      rdy = stall ? ((cyc % 3) != 2) : 1'b1;
      mem_ready = rdy;
      #1;
      if (mem_we !== 1'b1 || mem_addr !== base_tab[r] + 32'(4 * w)) begin
        if (!addr_bad) begin a_act = mem_addr; a_exp = base_tab[r] + 32'(4 * w); end
        addr_bad = 1;
      end
      if (mem_wdata !== 32'h0) data_bad = 1;
      if (poke && cyc == 50) begin
        trig_we = 1'b1; trig_mask = 4'hF;
      end
      @(negedge clk);
      trig_we = 1'b0; trig_mask = 4'h0;
      if (rdy) begin
        w++;
        if (w == words_tab[r]) begin
          exp_pend[r] = 1'b0;
          w = 0;
          r = lowest(exp_pend);
        end
      end
      cyc++;
    end
    mem_ready = 1'b1;
    // R3 R4 R5: address sequence covers selected regions in order
    check("R3/R4/R5 address sequence", !addr_bad, a_act, a_exp);
    check("R5 zero write data", !data_bad, 32'd0, 32'd0);
    check("R6 pending mask per region", !pend_bad, p_act, p_exp);
    if (poke) check("R8 trigger while busy ignored", !pend_bad && !addr_bad, p_act, p_exp);
    check("R7 no early done", !done_bad, 32'd1, 32'd0);
    check("R7 done at end", done === 1'b1 && busy === 1'b0, {30'd0, done, busy}, 32'd2);
    @(negedge clk);
    check("R7 done one cycle", done === 1'b0 && mem_we === 1'b0,
          {30'd0, done, mem_we}, 32'd0);
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check("R1 reset outputs", pend_mask === 4'h0 && busy === 1'b0 && done === 1'b0 && mem_we === 1'b0,
          {24'd0, pend_mask, busy, done, mem_we, 1'b0}, 32'd0);
  endtask

  task automatic t_zero_mask;
    @(negedge clk);
    trig_we = 1'b1; trig_mask = 4'h0;
    @(negedge clk);
    trig_we = 1'b0;
    // R2: empty mask leaves the block idle
    check("R2 zero mask ignored", busy === 1'b0 && pend_mask === 4'h0 && mem_we === 1'b0,
          {27'd0, pend_mask, busy}, 32'd0);
    @(negedge clk);
    check("R2 zero mask no done", done === 1'b0, {31'd0, done}, 32'd0);
  endtask

  task automatic t_reset_mid_run;
    @(negedge clk);
    trig_we = 1'b1; trig_mask = 4'h3;
    @(negedge clk);
    trig_we = 1'b0;
    repeat (20) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    // R9: run abandoned
    check("R9 idle after mid-run reset", busy === 1'b0 && pend_mask === 4'h0 && mem_we === 1'b0,
          {27'd0, pend_mask, busy}, 32'd0);
    @(negedge clk);
    check("R9 no done after reset", done === 1'b0, {31'd0, done}, 32'd0);
    // R9: fresh start from the lowest selected region
    @(negedge clk);
    trig_we = 1'b1; trig_mask = 4'h6;
    @(negedge clk);
    trig_we = 1'b0;
    check("R9 restart address", mem_addr === 32'h2000_8000 && mem_we === 1'b1,
          mem_addr, 32'h2000_8000);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    base_tab[0] = 32'h2000_0000; words_tab[0] = 32'h8000 / 4;
    base_tab[1] = 32'h2000_8000; words_tab[1] = 32'h8000 / 4;
    base_tab[2] = 32'h2001_0000; words_tab[2] = 32'hC000 / 4;
    base_tab[3] = 32'h2001_C000; words_tab[3] = 32'h4000 / 4;
    t_reset();
    t_zero_mask();
    run_mask(4'h8, 1'b0, 1'b0);
    run_mask(4'h5, 1'b1, 1'b0);
    run_mask(4'hA, 1'b1, 1'b0);
    run_mask(4'hF, 1'b0, 1'b1);
    t_reset_mid_run();
    run_mask(4'h1, 1'b0, 1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd190000, 32'd0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule